// File: doc/BRIEF.md
# Double-Pumped Single-Port RAM Wrapper

This block gives decoder logic a memory that accepts one read and one write in every cycle of its own clock, while only a single-port array sits underneath. The array runs on a clock twice as fast as the logic. The slow clock is formed as an enable from the fast clock, so the two stay in phase. Each slow cycle is split into two fast slots. The first slot serves the read and the second serves the write. Request inputs are held steady by the caller for the whole slow cycle.

A wide message word is built from several narrow single-port banks placed side by side. All banks share one address, so every 5-bit lane of the word moves together. The width of each bank is capped at 64 bits. The default build has 45 lanes, which gives a 225-bit word held in five 45-bit banks. A clear pass writes zeros to every address, one per slow cycle, before decoding starts. It reports busy while it runs and a sticky done flag when it finishes.

Top module: `dpump_ram`

## Requirements
- R1: After reset the slot indicator `wr_slot_o` is 0 (read slot), and it then alternates on every fast clock edge. A slow cycle starts on a fast edge where `wr_slot_o` goes to 0.
- R2: A read requested in a slow cycle (`rd_en_i`=1, `rd_addr_i`) appears on `rd_data_o` at the fast edge that ends that slow cycle, and it holds the word stored at that address.
- R3: A write requested in a slow cycle (`wr_en_i`=1) is stored during the write slot. A read of the same address in the same slow cycle returns the data from before the write.
- R4: Lane j of the word occupies bits [5j+4:5j]. All lanes are read and written together under one address. The word is split over banks of equal width, each a whole number of lanes and at most 64 bits wide.
- R5: In a slow cycle with `rd_en_i`=0, `rd_data_o` keeps its previous value.
- R6: When `clr_start_i` is 1 at the end of a slow cycle while no clear is running, `clr_done_o` drops to 0 and `clr_busy_o` goes to 1. Over the next DEPTH slow cycles a zero is written to each address in ascending order. At the end of the last of those cycles `clr_busy_o` goes to 0 and `clr_done_o` goes to 1. `clr_done_o` then stays at 1 until the next clear starts.
- R7: An external write that is requested while `clr_busy_o` is 1 is ignored.
- R8: During and right after reset, `rd_data_o` is all zeros and both `clr_busy_o` and `clr_done_o` are 0.
- R9: A slow cycle with `wr_en_i`=0 leaves the array unchanged, whatever `wr_addr_i` and `wr_data_i` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast memory clock, twice the logic rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read request for this slow cycle |
| rd_addr_i | input | AW | Read address |
| wr_en_i | input | 1 | Write request for this slow cycle |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | WORD_W | Write word, lanes packed from bit 0 |
| clr_start_i | input | 1 | Starts a zero-fill pass |
| rd_data_o | output | WORD_W | Read word, registered at the end of the slow cycle |
| wr_slot_o | output | 1 | 0 in the read slot, 1 in the write slot |
| clr_busy_o | output | 1 | Zero-fill pass in progress |
| clr_done_o | output | 1 | Sticky flag showing that a zero-fill pass has completed |

## Verification
The case hardest to reach from the ports is an external write that arrives in the final slot of a clear pass. At that point the clear walk has already gone past the target address. If the write were not blocked, it would survive the clear. The stimulus counts exactly DEPTH slow cycles after the start, issues a write to address 0 in the last one, and then reads address 0 expecting zero. A read and a write to the same address in one slow cycle is driven on purpose, as is the top address. These cases expose any swap of the two slots or any error in the address range.

// File: rtl/dpump_pkg.sv
package dpump_pkg;

  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/dpump_phase.sv
module dpump_phase
  import dpump_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic wr_slot_o
);

  slot_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= SLOT_RD;
    else         phase_q <= (phase_q == SLOT_RD) ? SLOT_WR : SLOT_RD;
  end

  assign wr_slot_o = (phase_q == SLOT_WR);

endmodule

// File: rtl/dpump_bank.sv
module dpump_bank #(
  parameter int W     = 45,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] q_q;

  // single port: one access per fast edge
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      q_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = q_q;

endmodule

// File: rtl/dpump_clear.sv
module dpump_clear #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_end_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          busy_q, done_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (slow_end_i) begin
      if (busy_q) begin
        if (cnt_q == LAST_ADDR) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign addr_o = cnt_q;

  // R6
  clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q));
  // R6
  clr_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  // R6
  clr_first_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q == '0));

endmodule

// File: rtl/dpump_ram.sv
module dpump_ram #(
  parameter int LANE_W = 5,
  parameter int LANES  = 45,
  parameter int BANK_W = 45,
  parameter int DEPTH  = 32,
  localparam int WORD_W = LANE_W * LANES,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              clr_start_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              wr_slot_o,
  output logic              clr_busy_o,
  output logic              clr_done_o
);

  localparam int NUM_BANKS = dpump_pkg::ceil_div(WORD_W, BANK_W);
  localparam int PAD_W     = NUM_BANKS * BANK_W;

  // R4
  initial begin
    bank_w_cap_chk: assert (BANK_W <= 64 && (BANK_W % LANE_W) == 0)
      else $error("bank width must be <= 64 and a whole number of lanes");
  end

  logic          wr_slot;
  logic          clr_busy, clr_done;
  logic [AW-1:0] clr_addr;

  dpump_phase i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_slot_o (wr_slot)
  );

  dpump_clear #(.DEPTH(DEPTH), .AW(AW)) i_clear (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slow_end_i (wr_slot),
    .start_i    (clr_start_i),
    .busy_o     (clr_busy),
    .done_o     (clr_done),
    .addr_o     (clr_addr)
  );

  logic             bank_en, bank_we;
  logic [AW-1:0]    bank_addr;
  logic [PAD_W-1:0] bank_wdata, bank_rdata;

  // read slot first, then write slot; clear owns the write slot
  always_comb begin
    bank_we    = wr_slot & (clr_busy | wr_en_i);
    bank_en    = wr_slot ? bank_we : rd_en_i;
    bank_addr  = !wr_slot ? rd_addr_i : (clr_busy ? clr_addr : wr_addr_i);
    bank_wdata = clr_busy ? '0 : PAD_W'(wr_data_i);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dpump_bank #(.W(BANK_W), .DEPTH(DEPTH), .AW(AW)) i_bank (
      .clk_i   (clk_i),
      .en_i    (bank_en),
      .we_i    (bank_we),
      .addr_i  (bank_addr),
      .wdata_i (bank_wdata[b*BANK_W +: BANK_W]),
      .rdata_o (bank_rdata[b*BANK_W +: BANK_W])
    );
  end

  logic              rd_pend_q;
  logic [WORD_W-1:0] rd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_data_q <= '0;
    end else if (!wr_slot) begin
      rd_pend_q <= rd_en_i;
    end else begin
      rd_pend_q <= 1'b0;
      if (rd_pend_q) rd_data_q <= bank_rdata[WORD_W-1:0];
    end
  end

  assign rd_data_o  = rd_data_q;
  assign wr_slot_o  = wr_slot;
  assign clr_busy_o = clr_busy;
  assign clr_done_o = clr_done;

  // R2
  rd_pend_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> wr_slot);
  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_slot || !rd_pend_q) |=> $stable(rd_data_q));
  // R7
  clr_wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_busy && bank_we) |-> (bank_wdata == '0 && bank_addr == clr_addr));

endmodule

// File: tb/test_dpump_ram.sv
module test_dpump_ram;

  localparam int LANE_W = 5;
  localparam int LANES  = 45;
  localparam int BANK_W = 45;
  localparam int DEPTH  = 32;
  localparam int AW     = 5;
  localparam int WW     = LANE_W * LANES;

  // {rd_en, rd_addr[4:0], wr_en, wr_addr[4:0], seed[7:0]}
  localparam int NVEC = 13;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  1'b1, 5'd3,  8'd11},
    {1'b0, 5'd0,  1'b1, 5'd7,  8'd22},
    {1'b1, 5'd3,  1'b0, 5'd0,  8'd0 },
    {1'b1, 5'd7,  1'b1, 5'd7,  8'd33},
    {1'b1, 5'd7,  1'b0, 5'd0,  8'd0 },
    {1'b1, 5'd31, 1'b1, 5'd31, 8'd44},
    {1'b1, 5'd31, 1'b1, 5'd0,  8'd55},
    {1'b1, 5'd0,  1'b0, 5'd0,  8'd0 },
    {1'b0, 5'd0,  1'b0, 5'd0,  8'd66},
    {1'b1, 5'd0,  1'b0, 5'd0,  8'd0 },
    {1'b0, 5'd0,  1'b1, 5'd5,  8'd77},
    {1'b1, 5'd5,  1'b1, 5'd5,  8'd88},
    {1'b1, 5'd5,  1'b0, 5'd0,  8'd0 }
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_en_i = 1'b0, wr_en_i = 1'b0, clr_start_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0, wr_addr_i = '0;
  logic [WW-1:0] wr_data_i = '0;
  logic [WW-1:0] rd_data_o;
  logic          wr_slot_o, clr_busy_o, clr_done_o;

  always #5 clk = ~clk;

  dpump_ram #(.LANE_W(LANE_W), .LANES(LANES), .BANK_W(BANK_W), .DEPTH(DEPTH)) i_dpump_ram (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .clr_start_i (clr_start_i),
    .rd_data_o   (rd_data_o),
    .wr_slot_o   (wr_slot_o),
    .clr_busy_o  (clr_busy_o),
    .clr_done_o  (clr_done_o)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [WW-1:0] model [DEPTH];
  logic [WW-1:0] exp_rd = '0;

  function automatic logic [WW-1:0] pat(input int seed);
    logic [WW-1:0] w;
    for (int j = 0; j < LANES; j++) w[j*LANE_W +: LANE_W] = LANE_W'((seed * 7 + j * 3) % 32);
    return w;
  endfunction

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call at a negedge inside the read slot; returns at the read slot of the next slow cycle
  task automatic op(input logic rd, input logic [AW-1:0] ra, input logic wr,
                    input logic [AW-1:0] wa, input logic [WW-1:0] wd, input logic clr);
    chk("R1 slot at slow start", WW'(wr_slot_o), '0);
    rd_en_i = rd; rd_addr_i = ra; wr_en_i = wr; wr_addr_i = wa; wr_data_i = wd;
    clr_start_i = clr;
    @(negedge clk);
    chk("R1 write slot", WW'(wr_slot_o), WW'(1));
    @(negedge clk);
    rd_en_i = 0; wr_en_i = 0; clr_start_i = 0;
  endtask

  task automatic run_clear(input bit inject);
    op(0, '0, 0, '0, '0, 1);
    chk("R6 busy after start", WW'({clr_busy_o, clr_done_o}), WW'(2'b10));
    for (int k = 0; k < DEPTH - 1; k++) op(0, '0, 0, '0, '0, 0);
    chk("R6 busy before last", WW'({clr_busy_o, clr_done_o}), WW'(2'b10));
    // R7: write in the final clear slot, after address 0 was already cleared
    op(0, '0, inject, '0, pat(99), 0);
    chk("R6 done after DEPTH cycles", WW'({clr_busy_o, clr_done_o}), WW'(2'b01));
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 rd_data reset", rd_data_o, '0);
    chk("R8 clear flags reset", WW'({clr_busy_o, clr_done_o}), '0);
    chk("R1 slot reset", WW'(wr_slot_o), '0);
    rst_ni = 1'b1;

    // R6 / R7 clear with an injected write
    run_clear(1);
    op(1, 5'd0, 0, '0, '0, 0);
    chk("R7 write during clear ignored", rd_data_o, '0);
    op(1, 5'd31, 0, '0, '0, 0);
    chk("R6 top address cleared", rd_data_o, '0);
    exp_rd = '0;

    // R2 R3 R5 R9 vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic rd, wr;
      logic [AW-1:0] ra, wa;
      logic [WW-1:0] wd;
      rd = VEC[v][19]; ra = VEC[v][18:14]; wr = VEC[v][13]; wa = VEC[v][12:8];
      wd = pat(int'(VEC[v][7:0]));
      if (rd) exp_rd = model[ra];
      if (wr) model[wa] = wd;
      op(rd, ra, wr, wa, wd, 0);
      chk($sformatf("R2 R3 R5 R9 vector %0d", v), rd_data_o, exp_rd);
    end

    // R4 lane positions
    begin
      logic [WW-1:0] lw;
      for (int j = 0; j < LANES; j++) lw[j*LANE_W +: LANE_W] = LANE_W'(j % 32);
      op(0, '0, 1, 5'd9, lw, 0);
      op(1, 5'd9, 0, '0, '0, 0);
      chk("R4 full word", rd_data_o, lw);
      chk("R4 lane 44 bits [224:220]", WW'(rd_data_o[224:220]), WW'(12));
      chk("R4 lane 9 bits [49:45]", WW'(rd_data_o[49:45]), WW'(9));
    end

    // R6 done stays set, then a new pass clears it
    chk("R6 done sticky", WW'(clr_done_o), WW'(1));
    run_clear(0);
    op(1, 5'd9, 0, '0, '0, 0);
    chk("R6 second pass zeroed", rd_data_o, '0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule